// File: doc/BRIEF.md
# Bitwise Ternary Lookup Logic Unit

This execution unit evaluates an arbitrary three-input Boolean function across a 64-bit word. An 8-bit immediate holds the function's truth table. For every bit position, the matching bits of three operands form a 3-bit index, and that index picks one bit of the immediate. The three operands are the destination register's previous contents and two source registers. Because the old destination value is one of the inputs, the operation reads, modifies and writes the destination.

A fused form is also supported. When a register copy directly precedes the operation, the fuse input makes the unit take the copy's source value in place of the old destination value. The pair then acts as a true three-in, one-out operation. When the record flag is set, the unit also produces a 4-bit condition field that classifies the signed result.

The control is a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is presented this cycle. The machine moves from `ST_IDLE` to `ST_RESULT` on an input strobe and stays in `ST_RESULT` while strobes keep arriving. It returns from `ST_RESULT` to `ST_IDLE` on any cycle with no strobe.

Top module: `tern_lut_unit`

## Requirements
- R1: For each bit i, the result bit equals `op_table[{third[i], op_a[i], op_b[i]}]`, where `third` is the third operand, `op_a` is source A and `op_b` is source B. The third operand is the most significant index bit and `op_b` is the least significant.
- R2: Every one of the 64 bit positions is evaluated independently with the same table, so the tables 0xF0, 0xCC and 0xAA reproduce the third operand, `op_a` and `op_b` respectively.
- R3: When `op_fuse` is 1, the third operand is `op_copy_src` and `op_old_dst` has no effect on the result.
- R4: When `op_fuse` is 0, the third operand is `op_old_dst` and `op_copy_src` has no effect on the result.
- R5: `res_valid` is 1 exactly in the cycle after a cycle with `op_valid` = 1, and back-to-back strobes give back-to-back results in order.
- R6: With record requested, `res_cr[3]` is set if the result is negative (bit 63 = 1), `res_cr[2]` is set if the result is positive and non-zero, and `res_cr[1]` is set if the result is zero. Exactly one of these three bits is set.
- R7: With record requested, `res_cr[0]` equals the `op_so` input sampled with the strobe, and `res_cr_valid` is 1.
- R8: Without record, a result is presented with `res_cr` = 0 and `res_cr_valid` = 0.
- R9: During and right after reset, `res_valid`, `res_result`, `res_cr` and `res_cr_valid` are all 0.
- R10: In a cycle without a strobe, the next cycle has `res_valid` = 0 and `res_result` keeps its previous value, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_old_dst | input | 64 | Previous destination value |
| op_src_a | input | 64 | Source register A |
| op_src_b | input | 64 | Source register B |
| op_copy_src | input | 64 | Source value of a fused preceding copy |
| op_fuse | input | 1 | Use `op_copy_src` as the third operand |
| op_table | input | 8 | Truth-table immediate |
| op_record | input | 1 | Request the condition field |
| op_so | input | 1 | Summary-overflow value for the condition field |
| res_valid | output | 1 | Result strobe |
| res_result | output | 64 | Result word |
| res_cr | output | 4 | Condition field {neg, pos, zero, so} |
| res_cr_valid | output | 1 | Condition field is meaningful |

## Verification
Every result, condition field and strobe is due exactly one rising edge after the cycle that carries `op_valid`. Nothing changes in any other cycle. The driver applies stimulus on a falling edge and queues the expected item. The monitor pops and compares on the next falling edge that shows `res_valid`, which is half a cycle after the capturing edge. After the queue drains, idle cycles with changing operand inputs confirm that the result holds and that no extra strobe appears.

// File: rtl/tern_lut_pkg.sv
package tern_lut_pkg;
    localparam int unsigned TLU_DATA_W = 64;
    localparam int unsigned TLU_IDX_W  = 3;
    localparam int unsigned TLU_TBL_W  = 1 << TLU_IDX_W;
    localparam int unsigned TLU_CR_W   = 4;

    localparam int unsigned CR_NEG  = 3;
    localparam int unsigned CR_POS  = 2;
    localparam int unsigned CR_ZERO = 1;
    localparam int unsigned CR_SO   = 0;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } tlu_state_e;
endpackage

// File: rtl/tern_lut_third_sel.sv
module tern_lut_third_sel #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              fuse,
    input  logic [DATA_W-1:0] old_dst,
    input  logic [DATA_W-1:0] copy_src,
    output logic [DATA_W-1:0] third
);
    always_comb begin
        third = fuse ? copy_src : old_dst;
    end
endmodule

// File: rtl/tern_lut_bitfn.sv
module tern_lut_bitfn #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [DATA_W-1:0]      third,
    input  logic [DATA_W-1:0]      src_a,
    input  logic [DATA_W-1:0]      src_b,
    input  logic [(1<<IDX_W)-1:0]  table_bits,
    output logic [DATA_W-1:0]      value
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic [IDX_W-1:0] sel;
        assign sel      = {third[g], src_a[g], src_b[g]};
        assign value[g] = table_bits[sel];
    end
endmodule

// File: rtl/tern_lut_cond.sv
module tern_lut_cond
    import tern_lut_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0]   value,
    input  logic                so,
    output logic [TLU_CR_W-1:0] cr
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg          = value[DATA_W-1];
        is_zero         = (value == '0);
        cr              = '0;
        cr[CR_NEG]      = is_neg;
        cr[CR_ZERO]     = is_zero;
        cr[CR_POS]      = !is_neg && !is_zero;
        cr[CR_SO]       = so;
    end
endmodule

// File: rtl/tern_lut_unit.sv
module tern_lut_unit
    import tern_lut_pkg::*;
#(
    parameter int unsigned DATA_W = TLU_DATA_W,
    parameter int unsigned IDX_W  = TLU_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [DATA_W-1:0]      op_old_dst,
    input  logic [DATA_W-1:0]      op_src_a,
    input  logic [DATA_W-1:0]      op_src_b,
    input  logic [DATA_W-1:0]      op_copy_src,
    input  logic                   op_fuse,
    input  logic [(1<<IDX_W)-1:0]  op_table,
    input  logic                   op_record,
    input  logic                   op_so,
    output logic                   res_valid,
    output logic [DATA_W-1:0]      res_result,
    output logic [TLU_CR_W-1:0]    res_cr,
    output logic                   res_cr_valid
);
    localparam int unsigned TBL_W = 1 << IDX_W;

    tlu_state_e           state_q;
    tlu_state_e           state_d;
    logic [DATA_W-1:0]    third;
    logic [DATA_W-1:0]    value;
    logic [TLU_CR_W-1:0]  cr_raw;

    tern_lut_third_sel #(.DATA_W(DATA_W)) u_sel (
        .fuse     (op_fuse),
        .old_dst  (op_old_dst),
        .copy_src (op_copy_src),
        .third    (third)
    );

    tern_lut_bitfn #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fn (
        .third      (third),
        .src_a      (op_src_a),
        .src_b      (op_src_b),
        .table_bits (op_table[TBL_W-1:0]),
        .value      (value)
    );

    tern_lut_cond #(.DATA_W(DATA_W)) u_cond (
        .value (value),
        .so    (op_so),
        .cr    (cr_raw)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!op_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_result   <= '0;
            res_cr       <= '0;
            res_cr_valid <= 1'b0;
        end else if (op_valid) begin
            res_result   <= value;
            res_cr       <= op_record ? cr_raw : '0;
            res_cr_valid <= op_record;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_result));
    // R8
    no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_record) |=> (res_cr == '0 && !res_cr_valid));
    // R6
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_cr_valid |-> ($countones(res_cr[CR_NEG:CR_ZERO]) == 1));
    // R6
    cr_zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_cr_valid |-> (res_cr[CR_ZERO] == (res_result == '0)));
    // R7
    cr_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_record) |=> (res_cr_valid && res_cr[CR_SO] == $past(op_so)));
endmodule

// File: tb/tern_lut_unit_test.sv
`timescale 1ns/1ps
module tern_lut_unit_test;
    typedef struct {
        logic [63:0] result;
        logic [3:0]  cr;
        logic        crv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_old_dst = '0, op_src_a = '0, op_src_b = '0, op_copy_src = '0;
    logic        op_fuse = 1'b0;
    logic [7:0]  op_table = '0;
    logic        op_record = 1'b0, op_so = 1'b0;
    logic        res_valid;
    logic [63:0] res_result;
    logic [3:0]  res_cr;
    logic        res_cr_valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];
    logic [63:0] last_result = '0;

    always #4 clk = ~clk;

    tern_lut_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_old_dst(op_old_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
        .op_copy_src(op_copy_src), .op_fuse(op_fuse), .op_table(op_table),
        .op_record(op_record), .op_so(op_so),
        .res_valid(res_valid), .res_result(res_result),
        .res_cr(res_cr), .res_cr_valid(res_cr_valid)
    );

    function automatic logic [63:0] model(logic [63:0] c, logic [63:0] a,
                                          logic [63:0] b, logic [7:0] t);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = t[{c[i], a[i], b[i]}];
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [63:0] old_d, logic [63:0] a,
                         logic [63:0] b, logic [63:0] cp, logic fuse,
                         logic [7:0] t, logic rec, logic so);
        exp_t e;
        logic [63:0] r;
        @(negedge clk);
        op_valid = 1'b1; op_old_dst = old_d; op_src_a = a; op_src_b = b;
        op_copy_src = cp; op_fuse = fuse; op_table = t; op_record = rec; op_so = so;
        r = model(fuse ? cp : old_d, a, b, t);
        e.result = r;
        e.crv = rec;
        e.cr = rec ? {r[63], (!r[63] && r != 0), (r == 0), so} : 4'b0;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle_cycle(logic [63:0] junk);
        @(negedge clk);
        op_valid = 1'b0; op_old_dst = junk; op_src_a = ~junk; op_src_b = junk ^ 64'h5A5A;
        op_copy_src = junk; op_table = junk[7:0];
    endtask

    // Monitor: pops expected items one cycle after each strobe
    always @(negedge clk) begin
        if (rst_n && res_valid && !done) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected result actual=%h expected=none", res_result);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " result"}, res_result, e.result);
                check("R6 R7 R8 cr", {60'd0, res_cr}, {60'd0, e.cr});
                check("R7 R8 cr_valid", {63'd0, res_cr_valid}, {63'd0, e.crv});
                last_result = e.result;
            end
        end
    end

    localparam logic [63:0] PA = 64'hF0F0_1234_89AB_CDEF;
    localparam logic [63:0] PB = 64'h0FF0_5555_3C3C_0001;
    localparam logic [63:0] PC = 64'h8000_FFFF_0000_AAAA;

    initial begin
        // R9: state during reset and right after release
        repeat (2) @(negedge clk);
        check("R9 valid in reset", {63'd0, res_valid}, 64'd0);
        check("R9 result in reset", res_result, 64'd0);
        check("R9 cr in reset", {59'd0, res_cr_valid, res_cr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", {63'd0, res_valid}, 64'd0);

        // R1/R2: copy tables and common functions, back-to-back (R5)
        drive("R2 table F0 third", PC, PA, PB, 64'hDEAD, 1'b0, 8'hF0, 1'b0, 1'b0);
        drive("R2 table CC srcA",  PC, PA, PB, 64'hDEAD, 1'b0, 8'hCC, 1'b0, 1'b0);
        drive("R2 table AA srcB",  PC, PA, PB, 64'hDEAD, 1'b0, 8'hAA, 1'b0, 1'b0);
        drive("R1 xor3",           PC, PA, PB, 64'h0,    1'b0, 8'h96, 1'b0, 1'b0);
        drive("R1 majority",       PC, PA, PB, 64'h0,    1'b0, 8'hE8, 1'b0, 1'b0);
        drive("R1 index order",    64'hFF00, 64'hF0F0, 64'hCCCC, 64'h0, 1'b0, 8'h01, 1'b0, 1'b0);
        // R3: fused form ignores old destination
        drive("R3 fuse third",     PC, PA, PB, 64'h1357_9BDF_2468_ACE0, 1'b1, 8'hF0, 1'b0, 1'b0);
        drive("R3 fuse xor3",      64'hFFFF_FFFF_FFFF_FFFF, PA, PB, PC, 1'b1, 8'h96, 1'b0, 1'b0);
        // R4: copy source ignored without fuse
        drive("R4 copy ignored",   PC, PA, PB, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'hF0, 1'b0, 1'b0);
        // R6/R7: record classes
        drive("R6 record zero",    PC, PA, PB, 64'h0, 1'b0, 8'h00, 1'b1, 1'b0);
        drive("R6 record negative",PC, PA, PB, 64'h0, 1'b0, 8'hFF, 1'b1, 1'b1);
        drive("R6 record positive",64'h0, 64'h1, 64'h0, 64'h0, 1'b0, 8'hCC, 1'b1, 1'b0);
        drive("R7 record so",      64'h0, 64'h7, 64'h0, 64'h0, 1'b0, 8'hCC, 1'b1, 1'b1);
        // R8: no record after record
        drive("R8 no record",      PC, PA, PB, 64'h0, 1'b0, 8'hFF, 1'b0, 1'b1);

        // R10: idle cycles with moving inputs
        idle_cycle(64'h1111);
        idle_cycle(64'h2222_3333);
        idle_cycle(64'h4444_0000_5555);
        @(negedge clk);
        check("R10 valid low", {63'd0, res_valid}, 64'd0);
        check("R10 result held", res_result, last_result);
        check("R5 queue drained", 64'(q.size()), 64'd0);

        // R5: single isolated strobe after idle
        drive("R5 isolated", PA, PB, PC, 64'h0, 1'b0, 8'h6A, 1'b0, 1'b0);
        idle_cycle(64'h9);
        @(negedge clk);
        check("R5 single pulse", {63'd0, res_valid}, 64'd0);
        check("R5 queue empty", 64'(q.size()), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule